// File: doc/BRIEF.md
# FP8 Pair Dot-Product Accumulator

This block is one arithmetic lane. Each operand word is 16 bits wide and carries two 8-bit floating-point values. The block multiplies the low byte of the first word by the low byte of the second, and the high byte by the high byte. It scales the sum of the two products by 2^-k and adds it to a half-precision accumulator. Everything up to the final result is exact, and the result is rounded to FP16 only once. Each operand word has its own format select, so the two words may use different 8-bit encodings.

Inputs enter through a valid/ready handshake and pass through a fixed two-stage pipeline, so the block can accept one operation per cycle. When the consumer holds ready low, the whole pipeline stalls and the output is held until it is taken.

Top module: `fp8_pair_dot_acc`

## Requirements
- R1: Byte 0 of `opA` is multiplied by byte 0 of `opB`, and byte 1 of `opA` by byte 1 of `opB`. Both products are added to `accIn`, which is an IEEE FP16 value.
- R2: `fmtA` selects the encoding of both bytes of `opA`, and `fmtB` selects the encoding of both bytes of `opB`. A select of 0 means E5M2: bias 15, exponent 31 with a zero mantissa is infinity, and exponent 31 with a nonzero mantissa is NaN. A select of 1 means E4M3: bias 7, no infinities, and only the pattern with exponent 15 and mantissa 7 is NaN. An exponent of 0 encodes a subnormal in both formats.
- R3: The sum of the two products is multiplied by 2^-`scaleK`, with `scaleK` from 0 to 15. The accumulator is not scaled.
- R4: The products, the scaling and the addition are exact. The only rounding is a single round-to-nearest-even step to FP16, and the sign of a nonzero result is the sign of the exact sum.
- R5: A finite result whose rounded magnitude is 65520 or more gives infinity of the sign of the sum (0x7C00 or 0xFC00).
- R6: A small result gives an FP16 subnormal, or a zero that carries the sign of the exact sum. An exact zero sum gives -0 (0x8000) only when the accumulator and both products are negative zeros, and +0 (0x0000) otherwise.
- R7: The result is 0x7E00 when any input is NaN, when a product is infinity times zero, or when infinities of opposite sign meet.
- R8: Otherwise, an infinite product or an infinite accumulator gives infinity of that sign.
- R9: An operation accepted on a clock edge with `outReady` held high appears on `result` with `outValid` two cycles later. Back-to-back operations give one result per cycle. While `outValid` is high and `outReady` is low, the output is held.
- R10: After reset, `outValid` is low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operation is valid |
| inReady | output | 1 | The block can accept an operation |
| opA | input | 16 | First operand word: two 8-bit floats |
| opB | input | 16 | Second operand word: two 8-bit floats |
| accIn | input | 16 | FP16 accumulator input |
| fmtA | input | 1 | Encoding of opA bytes (0 E5M2, 1 E4M3) |
| fmtB | input | 1 | Encoding of opB bytes (0 E5M2, 1 E4M3) |
| scaleK | input | 4 | Products are scaled by 2^-scaleK |
| outValid | output | 1 | Result is valid |
| outReady | input | 1 | Consumer takes the result |
| result | output | 16 | Rounded FP16 result |

## Verification
A wrong alignment shift or a lost low-order bit in the wide sum shows up on `result` two cycles after the operation is accepted. It appears as a last-place error on ties, as a wrong subnormal, or as a sign error on zeros. A mistake in special-value classification gives a non-canonical NaN or an infinity where a finite value is due, on the same cycle. A fault in the valid/ready control appears at once as a result that is missing, duplicated or out of order against the scoreboard queue, or as a latency other than two cycles while ready is held high.

// File: rtl/fp8dot_pkg.sv
package fp8dot_pkg;
  parameter int LANES    = 2;
  parameter int F8_W     = 8;
  parameter int F16_W    = 16;
  parameter int FRAC16   = 10;
  parameter int SCALE_W  = 4;
  // window LSB weight 2^-WIN_FRAC: min product 2^-34 scaled by 2^-15
  parameter int WIN_FRAC = 49;
  parameter int WIN_W    = 88;
  parameter int SIG_W    = 11;
  localparam int SUB_POS  = WIN_FRAC - 24;      // FP16 subnormal LSB
  localparam int NORM_MIN = SUB_POS + FRAC16;   // FP16 min normal MSB
  localparam int PROD_W   = 2 * SIG_W;

  typedef enum logic [1:0] {K_FIN, K_INF, K_NAN} kind_t;

  typedef struct packed {
    logic ld1;
    logic ld2;
  } ctl_t;

  typedef struct packed {
    logic              nan;
    logic              inf;
    logic              zero;
    logic              sgn;
    logic [SIG_W-1:0]  sig;
    logic signed [7:0] wexp;   // weight of sig LSB
  } opDec_t;

  function automatic opDec_t decodeFp8(input logic [F8_W-1:0] v, input logic fmt);
    opDec_t d;
    d = '0;
    d.sgn = v[7];
    if (!fmt) begin
      if (v[6:2] == 5'h1f) begin
        d.nan = (v[1:0] != 2'b00);
        d.inf = (v[1:0] == 2'b00);
      end else if (v[6:2] == 5'h00) begin
        d.sig  = {8'b0, v[1:0], 1'b0};
        d.wexp = -8'sd17;
      end else begin
        d.sig  = {8'b0, 1'b1, v[1:0], 1'b0};
        d.wexp = $signed({3'b000, v[6:2]}) - 8'sd18;
      end
    end else begin
      if (v[6:0] == 7'h7f) begin
        d.nan = 1'b1;
      end else if (v[6:3] == 4'h0) begin
        d.sig  = {8'b0, v[2:0]};
        d.wexp = -8'sd9;
      end else begin
        d.sig  = {7'b0, 1'b1, v[2:0]};
        d.wexp = $signed({4'b0000, v[6:3]}) - 8'sd10;
      end
    end
    d.zero = !d.nan && !d.inf && (d.sig == '0);
    return d;
  endfunction

  function automatic opDec_t decodeFp16(input logic [F16_W-1:0] v);
    opDec_t d;
    d = '0;
    d.sgn = v[15];
    if (v[14:10] == 5'h1f) begin
      d.nan = (v[9:0] != '0);
      d.inf = (v[9:0] == '0);
    end else if (v[14:10] == 5'h00) begin
      d.sig  = {1'b0, v[9:0]};
      d.wexp = -8'sd24;
    end else begin
      d.sig  = {1'b1, v[9:0]};
      d.wexp = $signed({3'b000, v[14:10]}) - 8'sd25;
    end
    d.zero = !d.nan && !d.inf && (d.sig == '0);
    return d;
  endfunction
endpackage

// File: rtl/fp8dot_ctrl.sv
module fp8dot_ctrl
  import fp8dot_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  output logic outValid,
  input  logic outReady,
  output ctl_t ctl
);
  logic stage1Valid, stage2Valid, advance;

  assign advance  = !stage2Valid || outReady;
  assign inReady  = advance;
  assign outValid = stage2Valid;
  assign ctl.ld1  = advance && inValid;
  assign ctl.ld2  = advance && stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else if (advance) begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);
  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##1 outValid);
endmodule

// File: rtl/fp8dot_dp.sv
module fp8dot_dp
  import fp8dot_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctl_t                ctl,
  input  logic [F16_W-1:0]    opA,
  input  logic [F16_W-1:0]    opB,
  input  logic [F16_W-1:0]    accIn,
  input  logic                fmtA,
  input  logic                fmtB,
  input  logic [SCALE_W-1:0]  scaleK,
  output logic [F16_W-1:0]    result
);
  // ---------------- stage 1: decode, products, exact sum ----------------
  logic signed [WIN_W-1:0] laneTerm [LANES];
  logic [LANES-1:0] laneNan, laneInf, laneSgn, laneNegZero;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    opDec_t dA, dB;
    logic [PROD_W-1:0] prod;
    logic [WIN_W-1:0]  mag;
    int                shAmt;
    always_comb begin
      dA    = decodeFp8(opA[g*F8_W +: F8_W], fmtA);
      dB    = decodeFp8(opB[g*F8_W +: F8_W], fmtB);
      prod  = {{SIG_W{1'b0}}, dA.sig} * {{SIG_W{1'b0}}, dB.sig};
      shAmt = int'(dA.wexp) + int'(dB.wexp) + WIN_FRAC - int'(scaleK);
      mag   = WIN_W'(prod) << shAmt;
      laneSgn[g]     = dA.sgn ^ dB.sgn;
      laneTerm[g]    = laneSgn[g] ? -$signed(mag) : $signed(mag);
      laneNan[g]     = dA.nan || dB.nan || (dA.inf && dB.zero) || (dA.zero && dB.inf);
      laneInf[g]     = (dA.inf || dB.inf) && !laneNan[g];
      laneNegZero[g] = (dA.zero || dB.zero) && laneSgn[g];
    end
  end

  opDec_t dC;
  logic [WIN_W-1:0]        accMag;
  logic signed [WIN_W-1:0] sumNext;
  logic posInf, negInf, anyNan, allNegZero;
  kind_t kindNext;

  always_comb begin
    dC      = decodeFp16(accIn);
    accMag  = WIN_W'(dC.sig) << (int'(dC.wexp) + WIN_FRAC);
    sumNext = dC.sgn ? -$signed(accMag) : $signed(accMag);
    anyNan  = dC.nan;
    posInf  = dC.inf && !dC.sgn;
    negInf  = dC.inf && dC.sgn;
    allNegZero = dC.zero && dC.sgn;
    for (int l = 0; l < LANES; l++) begin
      sumNext    = sumNext + laneTerm[l];
      anyNan     = anyNan || laneNan[l];
      posInf     = posInf || (laneInf[l] && !laneSgn[l]);
      negInf     = negInf || (laneInf[l] && laneSgn[l]);
      allNegZero = allNegZero && laneNegZero[l];
    end
    if (anyNan || (posInf && negInf)) kindNext = K_NAN;
    else if (posInf || negInf)        kindNext = K_INF;
    else                              kindNext = K_FIN;
  end

  logic signed [WIN_W-1:0] s1Sum;
  kind_t s1Kind;
  logic  s1InfNeg, s1ZeroNeg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sum     <= '0;
      s1Kind    <= K_FIN;
      s1InfNeg  <= 1'b0;
      s1ZeroNeg <= 1'b0;
    end else if (ctl.ld1) begin
      s1Sum     <= sumNext;
      s1Kind    <= kindNext;
      s1InfNeg  <= negInf;
      s1ZeroNeg <= allNegZero;
    end
  end

  // ---------------- stage 2: normalize and round once ----------------
  logic [WIN_W-1:0] absSum, belowMask;
  logic             sumNeg, guardBit, stickyBit;
  logic [SIG_W-1:0] mant;
  logic [SIG_W:0]   rnd;
  int               lead, lsbPos, expField, raw;
  logic [F16_W-1:0] resNext;

  always_comb begin
    sumNeg = s1Sum[WIN_W-1];
    absSum = sumNeg ? WIN_W'(-s1Sum) : WIN_W'(s1Sum);
    lead = 0;
    for (int i = 0; i < WIN_W; i++)
      if (absSum[i]) lead = i;
    lsbPos    = (lead >= NORM_MIN) ? lead - FRAC16 : SUB_POS;
    expField  = (lead >= NORM_MIN) ? lead - NORM_MIN : 0;
    mant      = SIG_W'(absSum >> lsbPos);
    guardBit  = absSum[lsbPos-1];
    belowMask = (WIN_W'(1) << (lsbPos - 1)) - WIN_W'(1);
    stickyBit = |(absSum & belowMask);
    rnd       = {1'b0, mant} + {{SIG_W{1'b0}}, guardBit && (stickyBit || mant[0])};
    raw       = expField * 1024 + int'(rnd);
    case (s1Kind)
      K_NAN:   resNext = 16'h7E00;
      K_INF:   resNext = {s1InfNeg, 15'h7C00};
      default: begin
        if (absSum == '0)     resNext = {s1ZeroNeg, 15'h0000};
        else if (raw >= 31744) resNext = {sumNeg, 15'h7C00};
        else                   resNext = {sumNeg, raw[14:0]};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        result <= '0;
    else if (ctl.ld2) result <= resNext;
  end

  p_nan_canon_r7: assert property (@(posedge clk) disable iff (!rstN)
    (result[14:10] == 5'h1f && result[9:0] != '0) |-> (result == 16'h7E00));
  p_nan_src_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld1 && accIn[14:10] == 5'h1f && accIn[9:0] != '0) |=> (s1Kind == K_NAN));
  p_inf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld2 && s1Kind == K_INF) |=> (result[14:0] == 15'h7C00));
  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld2 && s1Kind == K_FIN && s1Sum == '0) |=> (result[14:0] == 15'h0000));
  p_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ld2 && s1Kind == K_FIN && s1Sum[WIN_W-1]) |=> result[15]);
endmodule

// File: rtl/fp8_pair_dot_acc.sv
module fp8_pair_dot_acc
  import fp8dot_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [F16_W-1:0]    opA,
  input  logic [F16_W-1:0]    opB,
  input  logic [F16_W-1:0]    accIn,
  input  logic                fmtA,
  input  logic                fmtB,
  input  logic [SCALE_W-1:0]  scaleK,
  output logic                outValid,
  input  logic                outReady,
  output logic [F16_W-1:0]    result
);
  ctl_t ctl;

  fp8dot_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .ctl      (ctl)
  );

  fp8dot_dp uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .accIn  (accIn),
    .fmtA   (fmtA),
    .fmtB   (fmtB),
    .scaleK (scaleK),
    .result (result)
  );
endmodule

// File: tb/fp8_pair_dot_acc_test.sv
module fp8_pair_dot_acc_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [15:0] opA = '0, opB = '0, accIn = '0;
  logic fmtA = 1'b0, fmtB = 1'b0;
  logic [3:0] scaleK = '0;
  logic inReady, outValid;
  logic [15:0] result;

  int total = 0, bad = 0, cyc = 0;
  bit checkLat = 1'b0;
  logic [15:0] expQ[$];
  string tagQ[$];
  int cycQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fp8_pair_dot_acc uut (.*);

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- reference model on real values ----------------
  function automatic real f8Val(input logic [7:0] v, input bit fmt);
    real r;
    int e, m;
    if (!fmt) begin
      e = int'(v[6:2]); m = int'(v[1:0]);
      r = (e == 0) ? (m / 4.0) * 2.0 ** (-14) : (1.0 + m / 4.0) * 2.0 ** (e - 15);
    end else begin
      e = int'(v[6:3]); m = int'(v[2:0]);
      r = (e == 0) ? (m / 8.0) * 2.0 ** (-6) : (1.0 + m / 8.0) * 2.0 ** (e - 7);
    end
    return v[7] ? -r : r;
  endfunction

  function automatic bit f8Nan(input logic [7:0] v, input bit fmt);
    return fmt ? (v[6:0] == 7'h7f) : (v[6:2] == 5'h1f && v[1:0] != 0);
  endfunction

  function automatic bit f8Inf(input logic [7:0] v, input bit fmt);
    return !fmt && v[6:0] == 7'h7c;
  endfunction

  function automatic real f16Val(input logic [15:0] v);
    real r;
    int e, f;
    e = int'(v[14:10]); f = int'(v[9:0]);
    r = (e == 0) ? (f / 1024.0) * 2.0 ** (-14) : (1.0 + f / 1024.0) * 2.0 ** (e - 15);
    return v[15] ? -r : r;
  endfunction

  function automatic logic signed [127:0] toFix(input real x);
    real ax;
    longint hi, lo;
    logic signed [127:0] r;
    ax = (x < 0.0) ? -x : x;
    hi = longint'($floor(ax / 2.0 ** 40));
    lo = longint'(ax - real'(hi) * 2.0 ** 40);
    r  = (128'(hi) << 40) + 128'(lo);
    return (x < 0.0) ? -r : r;
  endfunction

  function automatic logic [127:0] codeFix(input int code);
    int e, f;
    e = code >> 10; f = code & 1023;
    if (e == 0) return 128'(f) << 25;
    return 128'(1024 + f) << (e + 24);
  endfunction

  function automatic logic [15:0] refModel(input logic [15:0] a, input logic [15:0] b,
      input logic [15:0] c, input bit fa, input bit fb, input int k);
    bit nan, pInf, nInf, allNegZ, neg;
    logic signed [127:0] s;
    logic [127:0] m;
    int lo, hi, mid, pick;
    nan = (c[14:10] == 5'h1f && c[9:0] != 0);
    pInf = (c[14:0] == 15'h7c00) && !c[15];
    nInf = (c[14:0] == 15'h7c00) && c[15];
    allNegZ = (c == 16'h8000);
    s = toFix(f16Val(c) * 2.0 ** 49);
    for (int l = 0; l < 2; l++) begin
      logic [7:0] x, y;
      real xv, yv;
      x = a[8*l +: 8]; y = b[8*l +: 8];
      xv = f8Val(x, fa); yv = f8Val(y, fb);
      if (f8Nan(x, fa) || f8Nan(y, fb) || (f8Inf(x, fa) && yv == 0.0) || (f8Inf(y, fb) && xv == 0.0))
        nan = 1;
      else if (f8Inf(x, fa) || f8Inf(y, fb)) begin
        if (x[7] ^ y[7]) nInf = 1; else pInf = 1;
      end else
        s = s + toFix(xv * yv * 2.0 ** (49 - k));
      allNegZ = allNegZ && (xv == 0.0 || yv == 0.0) && (x[7] ^ y[7]);
    end
    if (nan || (pInf && nInf)) return 16'h7E00;
    if (pInf) return 16'h7C00;
    if (nInf) return 16'hFC00;
    if (s == 0) return allNegZ ? 16'h8000 : 16'h0000;
    neg = s < 0;
    m = neg ? 128'(-s) : 128'(s);
    if (m >= codeFix(16'h7BFF) + (128'(1) << 53)) return {neg, 15'h7C00};
    lo = 0; hi = 16'h7BFF;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (codeFix(mid) <= m) lo = mid; else hi = mid - 1;
    end
    pick = lo;
    if (lo < 16'h7BFF && codeFix(lo) != m) begin
      if (m - codeFix(lo) > codeFix(lo + 1) - m) pick = lo + 1;
      else if (m - codeFix(lo) == codeFix(lo + 1) - m) pick = (lo % 2 == 0) ? lo : lo + 1;
    end
    return {neg, 15'(pick)};
  endfunction

  // ---------------- driver ----------------
  task automatic sendOp(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
      input bit fa, input bit fb, input int k, input string tag,
      input bit useExp = 0, input logic [15:0] expV = '0);
    logic [15:0] e;
    e = useExp ? expV : refModel(a, b, c, fa, fb, k);
    @(negedge clk);
    opA = a; opB = b; accIn = c; fmtA = fa; fmtB = fb; scaleK = 4'(k); inValid = 1'b1;
    #2;
    while (!inReady) begin
      @(negedge clk);
      #2;
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    cycQ.push_back(cyc);
  endtask

  // ---------------- monitor ----------------
  always begin
    @(negedge clk);
    outReady = checkLat ? 1'b1 : ($urandom % 4 != 0);
    #2;
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected output", result, 16'hxxxx);
      end else begin
        logic [15:0] e;
        string t;
        int c0;
        e = expQ.pop_front(); t = tagQ.pop_front(); c0 = cycQ.pop_front();
        check(result === e, t, result, e);
        if (checkLat) check(cyc - c0 == 2, "R9 latency", 16'(cyc - c0), 16'd2);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [7:0] specials [12] = '{8'h00, 8'h80, 8'h7C, 8'hFC, 8'h7F, 8'hFF,
                                8'h7E, 8'h7B, 8'h01, 8'h81, 8'h78, 8'h3C};
  logic [15:0] accSpec [6] = '{16'h0000, 16'h8000, 16'h7C00, 16'hFC00, 16'h7E00, 16'h3C00};

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(outValid == 1'b0, "R10 outValid after reset", {15'b0, outValid}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check(outValid == 1'b0, "R10 outValid idle", {15'b0, outValid}, 16'h0);
    check(inReady == 1'b1, "R10 inReady idle", {15'b0, inReady}, 16'h1);

    // R9: latency and throughput with ready held high
    checkLat = 1'b1;
    for (int i = 0; i < 8; i++)
      sendOp(16'h3C3C, 16'h3C3C, 16'(i) << 10, 0, 0, 0, "R9 back-to-back");
    @(negedge clk) inValid = 1'b0;
    repeat (4) @(negedge clk);
    checkLat = 1'b0;

    // R1: lane pairing, 2*3 + 1*0.5 = 6.5
    sendOp(16'h3C40, 16'h3842, 16'h0000, 0, 0, 0, "R1 pairing", 1, 16'h4680);
    // R3: scale products, not accumulator
    sendOp(16'h3C40, 16'h3842, 16'h0000, 0, 0, 2, "R3 scale 2^-2", 1, 16'h3E80);
    sendOp(16'h3C40, 16'h3842, 16'h3C00, 0, 0, 2, "R3 acc unscaled", 1, 16'h4140);
    // R2: mixed formats and E4M3 top value
    sendOp(16'h3838, 16'h3C3C, 16'h0000, 1, 0, 0, "R2 mixed formats", 1, 16'h4000);
    sendOp(16'h3C3C, 16'h3838, 16'h0000, 0, 1, 0, "R2 mixed swapped", 1, 16'h4000);
    sendOp(16'h007E, 16'h0038, 16'h0000, 1, 1, 0, "R2 E4M3 448", 1, 16'h5F00);
    // R4: single rounding, tie to even versus sticky
    sendOp(16'h013C, 16'h3C3C, 16'h6800, 0, 0, 0, "R4 fused sticky", 1, 16'h6801);
    sendOp(16'h003C, 16'h003C, 16'h6800, 0, 0, 0, "R4 tie to even", 1, 16'h6800);
    // R5: overflow
    sendOp(16'h007B, 16'h007B, 16'h0000, 0, 0, 0, "R5 overflow pos", 1, 16'h7C00);
    sendOp(16'h00FB, 16'h007B, 16'h0000, 0, 0, 0, "R5 overflow neg", 1, 16'hFC00);
    // R6: subnormal and signed zeros
    sendOp(16'h0001, 16'h0001, 16'h0000, 1, 1, 0, "R6 subnormal", 1, 16'h0040);
    sendOp(16'h0001, 16'h0001, 16'h0000, 1, 1, 15, "R6 tiny to +0", 1, 16'h0000);
    sendOp(16'h0081, 16'h0001, 16'h0000, 1, 1, 15, "R6 tiny to -0", 1, 16'h8000);
    sendOp(16'h8080, 16'h0000, 16'h8000, 1, 1, 0, "R6 all -0", 1, 16'h8000);
    sendOp(16'h8080, 16'h0000, 16'h0000, 1, 1, 0, "R6 mixed zero", 1, 16'h0000);
    sendOp(16'h003C, 16'h003C, 16'hBC00, 0, 0, 0, "R6 cancel +0", 1, 16'h0000);
    // R7: NaN cases
    sendOp(16'h007F, 16'h0038, 16'h0000, 1, 1, 0, "R7 E4M3 NaN", 1, 16'h7E00);
    sendOp(16'h007C, 16'h0000, 16'h0000, 0, 0, 0, "R7 inf times zero", 1, 16'h7E00);
    sendOp(16'hFC7C, 16'h3C3C, 16'h0000, 0, 0, 0, "R7 opposite inf", 1, 16'h7E00);
    sendOp(16'h3C3C, 16'h3C3C, 16'h7E01, 0, 0, 0, "R7 acc NaN", 1, 16'h7E00);
    // R8: infinity propagation
    sendOp(16'h3C3C, 16'h3C3C, 16'hFC00, 0, 0, 0, "R8 acc inf", 1, 16'hFC00);
    sendOp(16'h007C, 16'h0040, 16'h3C00, 0, 0, 0, "R8 product inf", 1, 16'h7C00);

    // special-value sweep against the model (R7, R8, R2)
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          sendOp({8'h38, specials[i]}, {8'h3C, specials[j]}, accSpec[(i + j) % 6],
                 f[0], f[1], (i * 12 + j) % 16, "R7 R8 special sweep");

    // random normals and subnormals, all scales and format pairs (R1 R3 R4 R5 R6)
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 16; k++)
        for (int n = 0; n < 20; n++) begin
          logic [15:0] a, b, c;
          a = 16'($urandom); b = 16'($urandom); c = 16'($urandom);
          if (n % 3 == 0) c = {c[15], 5'(c[14:10] % 8), c[9:0]};
          sendOp(a, b, c, f[0], f[1], k, "R4 random fused");
        end

    @(negedge clk) inValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule